// File: doc/BRIEF.md
# System Mask Set Execution Unit

This block carries out the privileged instruction that overwrites the leading byte of the program status word with one byte read from storage. On a `go` pulse it captures the instruction text, the current PSW, control register 0 and the mode flag (EC or BC). It then walks a short sequence: permission checks, one operand fetch, commit of the new byte, and a post-load validity check. Finally it raises a one-cycle `done` pulse. The pulse carries the resulting PSW, an exception code, a completed-or-suppressed flag and the instruction-length code to report.

Two kinds of failure are kept apart. Permission and fetch failures leave the PSW exactly as captured, so the operation is suppressed. The specification failure is found only after the new byte is in place, so the instruction counts as completed with the new byte kept.

Address generation, the storage system and the interrupt handling that follows an exception all sit outside the block. The block only hands the address field of the instruction to the fetch port.

Top module: `ssm_exec`

## Requirements
- R1: On success, `psw_out[63:56]` (PSW bits 0 to 7, bit 0 being the MSB) equals the fetched byte. `psw_out[55:0]`, including the condition code, equals the captured PSW. `exc_code` is 0, `completed` is 1 and `ilc` is 0.
- R2: If PSW bit 15 (problem state, `psw_in[48]`) is one, the result is `exc_code` 1 (privileged operation). The operation is suppressed (`completed` 0), no fetch is requested and `psw_out` equals the captured PSW.
- R3: In supervisor state with control register 0 bit 1 (`cr0_in[30]`) set, the result is `exc_code` 2 (special operation). The operation is suppressed, no fetch is requested and the PSW is unchanged.
- R4: A fetch answered with `fetch_err` high gives `exc_code` 3 (access). The operation is suppressed and the PSW is unchanged.
- R5: Only one exception is reported, with privileged operation first, then special operation, then access. When the state check fails, `fetch_req` never rises.
- R6: In EC mode (`ec_mode` 1), a loaded byte with bit 0 or any of bits 2 to 5 set (mask 8'hBC on the byte) still lands in `psw_out[63:56]`. It is reported as `exc_code` 4 with `completed` 1 and `ilc` 2.
- R7: In BC mode (`ec_mode` 0), no post-load check is made, so any byte value completes with `exc_code` 0.
- R8: Instruction bits 8 to 15 (`ins_text[23:16]`) have no effect. While `fetch_req` is high, `fetch_fld` equals instruction bits 16 to 31 (`ins_text[15:0]`).
- R9: `done` is high for exactly one cycle per instruction. `ilc` is 2 whenever `exc_code` is nonzero and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, taken only when idle |
| ins_text | input | 32 | Instruction text, bit 0 at the MSB |
| psw_in | input | 64 | Current PSW |
| cr0_in | input | 32 | Control register 0 |
| ec_mode | input | 1 | 1 = EC mode, 0 = BC mode |
| fetch_req | output | 1 | Operand fetch request, held until acknowledged |
| fetch_fld | output | 16 | Base and displacement field for address generation |
| fetch_ack | input | 1 | Fetch response valid |
| fetch_err | input | 1 | Fetch failed with protection or addressing error |
| fetch_data | input | 8 | Fetched operand byte |
| done | output | 1 | One-cycle end-of-instruction pulse |
| completed | output | 1 | 1 = completed, 0 = suppressed |
| exc_code | output | 3 | 0 none, 1 privileged, 2 special op, 3 access, 4 specification |
| ilc | output | 2 | Instruction-length code to report |
| psw_out | output | 64 | Resulting PSW |

## Verification
The assertions assume that `fetch_ack` is only ever high while `fetch_req` is high, and that each request gets a single acknowledge. They also assume `go` arrives only while the unit is idle. The stimulus keeps within these assumptions: it issues a new instruction only after the previous `done`, and it answers each request with one acknowledge cycle. The checks on suppression and on the kept lower PSW bits rely on the captured PSW copy staying still until `done`.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  typedef enum logic [2:0] {
    EXC_NONE   = 3'd0,
    EXC_PRIV   = 3'd1,
    EXC_SPECOP = 3'd2,
    EXC_ACCESS = 3'd3,
    EXC_SPEC   = 3'd4
  } exc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_COMMIT,
    ST_POST,
    ST_DONE
  } st_e;

  // MSB-first bit number to vector index
  function automatic int msb_pos(input int width, input int bitno);
    return width - 1 - bitno;
  endfunction

endpackage

// File: rtl/ssm_rst_sync.sv
module ssm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sh_q[STAGES-1];
endmodule

// File: rtl/ssm_gate.sv
module ssm_gate
  import ssm_pkg::*;
#(
  parameter int PSW_W     = 64,
  parameter int CR_W      = 32,
  parameter int PROB_BIT  = 15,
  parameter int SUPPR_BIT = 1
) (
  input  logic [PSW_W-1:0] psw,
  input  logic [CR_W-1:0]  cr0,
  output exc_e             pre_exc
);
  localparam int PROB_POS  = msb_pos(PSW_W, PROB_BIT);
  localparam int SUPPR_POS = msb_pos(CR_W, SUPPR_BIT);

  logic in_problem;
  logic mask_blocked;

  assign in_problem   = psw[PROB_POS];
  assign mask_blocked = cr0[SUPPR_POS];

  always_comb begin
    if (in_problem)        pre_exc = EXC_PRIV;
    else if (mask_blocked) pre_exc = EXC_SPECOP;
    else                   pre_exc = EXC_NONE;
  end
endmodule

// File: rtl/ssm_spec_chk.sv
module ssm_spec_chk #(
  parameter int               MASK_W = 8,
  parameter logic [MASK_W-1:0] RSVD  = 8'hBC
) (
  input  logic              ec,
  input  logic [MASK_W-1:0] new_byte,
  output logic              spec_bad
);
  logic [MASK_W-1:0] hit;

  for (genvar i = 0; i < MASK_W; i++) begin : g_bit
    if (RSVD[i]) begin : g_chk
      assign hit[i] = new_byte[i];
    end else begin : g_skip
      assign hit[i] = 1'b0;
    end
  end

  assign spec_bad = ec & (|hit);
endmodule

// File: rtl/ssm_state_regs.sv
module ssm_state_regs #(
  parameter int PSW_W  = 64,
  parameter int CR_W   = 32,
  parameter int MASK_W = 8,
  parameter int FLD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              cap_en,
  input  logic [PSW_W-1:0]  psw_in,
  input  logic [CR_W-1:0]   cr0_in,
  input  logic              ec_in,
  input  logic [FLD_W-1:0]  fld_in,
  input  logic              byte_en,
  input  logic [MASK_W-1:0] byte_in,
  input  logic              load_en,
  output logic [PSW_W-1:0]  psw_q,
  output logic [PSW_W-1:0]  base_q,
  output logic [CR_W-1:0]   cr0_q,
  output logic              ec_q,
  output logic [FLD_W-1:0]  fld_q
);
  localparam int KEEP_W = PSW_W - MASK_W;

  logic [MASK_W-1:0] byte_q;
  logic [PSW_W-1:0]  psw_d;

  always_comb begin
    psw_d = psw_q;
    if (cap_en)       psw_d = psw_in;
    else if (load_en) psw_d = {byte_q, psw_q[KEEP_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      psw_q  <= '0;
      base_q <= '0;
      cr0_q  <= '0;
      ec_q   <= 1'b0;
      fld_q  <= '0;
      byte_q <= '0;
    end else begin
      if (cap_en || load_en) psw_q <= psw_d;
      if (cap_en) begin
        base_q <= psw_in;
        cr0_q  <= cr0_in;
        ec_q   <= ec_in;
        fld_q  <= fld_in;
      end
      if (byte_en) byte_q <= byte_in;
    end
  end
endmodule

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
  import ssm_pkg::*;
#(
  parameter int ILC_W     = 2,
  parameter int ILC_VALUE = 2
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             go,
  input  exc_e             pre_exc,
  input  logic             fetch_ack,
  input  logic             fetch_err,
  input  logic             spec_bad,
  output logic             cap_en,
  output logic             byte_en,
  output logic             load_en,
  output logic             fetch_req,
  output logic             done,
  output logic             completed,
  output exc_e             exc_q,
  output logic [ILC_W-1:0] ilc
);
  st_e  st_q, st_d;
  exc_e exc_d;
  logic cmp_q, cmp_d;

  always_comb begin
    st_d  = st_q;
    exc_d = exc_q;
    cmp_d = cmp_q;
    case (st_q)
      ST_IDLE: if (go) begin
        st_d  = ST_CHECK;
        exc_d = EXC_NONE;
        cmp_d = 1'b0;
      end
      ST_CHECK: begin
        if (pre_exc != EXC_NONE) begin
          exc_d = pre_exc;
          st_d  = ST_DONE;
        end else begin
          st_d = ST_FETCH;
        end
      end
      ST_FETCH: if (fetch_ack) begin
        if (fetch_err) begin
          exc_d = EXC_ACCESS;
          st_d  = ST_DONE;
        end else begin
          st_d = ST_COMMIT;
        end
      end
      ST_COMMIT: begin
        cmp_d = 1'b1;
        st_d  = ST_POST;
      end
      ST_POST: begin
        if (spec_bad) exc_d = EXC_SPEC;
        st_d = ST_DONE;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q  <= ST_IDLE;
      exc_q <= EXC_NONE;
      cmp_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      exc_q <= exc_d;
      cmp_q <= cmp_d;
    end
  end

  assign cap_en    = (st_q == ST_IDLE) && go;
  assign fetch_req = (st_q == ST_FETCH);
  assign byte_en   = fetch_req && fetch_ack && !fetch_err;
  assign load_en   = (st_q == ST_COMMIT);
  assign done      = (st_q == ST_DONE);
  assign completed = cmp_q;
  assign ilc       = (done && exc_q != EXC_NONE) ? ILC_W'(ILC_VALUE) : '0;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_sn)
    done |=> !done); // R9
  AST_FETCH_CLEARED: assert property (@(posedge clk) disable iff (!rst_sn)
    fetch_req |-> (pre_exc == EXC_NONE)); // R5
  AST_SPEC_COMPLETE: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && exc_q == EXC_SPEC) |-> (completed && ilc == ILC_W'(ILC_VALUE))); // R6
  AST_ACK_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_sn)
    fetch_ack |-> fetch_req); // R4
endmodule

// File: rtl/ssm_exec.sv
module ssm_exec
  import ssm_pkg::*;
#(
  parameter int PSW_W  = 64,
  parameter int CR_W   = 32,
  parameter int INS_W  = 32,
  parameter int MASK_W = 8,
  parameter int FLD_W  = 16,
  parameter int ILC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [INS_W-1:0]  ins_text,
  input  logic [PSW_W-1:0]  psw_in,
  input  logic [CR_W-1:0]   cr0_in,
  input  logic              ec_mode,
  output logic              fetch_req,
  output logic [FLD_W-1:0]  fetch_fld,
  input  logic              fetch_ack,
  input  logic              fetch_err,
  input  logic [MASK_W-1:0] fetch_data,
  output logic              done,
  output logic              completed,
  output logic [2:0]        exc_code,
  output logic [ILC_W-1:0]  ilc,
  output logic [PSW_W-1:0]  psw_out
);
  localparam int KEEP_W = PSW_W - MASK_W;

  logic             rst_sn;
  logic             cap_en, byte_en, load_en, spec_bad, ec_q;
  logic [PSW_W-1:0] psw_q, base_q;
  logic [CR_W-1:0]  cr0_q;
  exc_e             pre_exc, exc_q;

  ssm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  ssm_state_regs #(
    .PSW_W(PSW_W), .CR_W(CR_W), .MASK_W(MASK_W), .FLD_W(FLD_W)
  ) u_regs (
    .clk(clk), .rst_sn(rst_sn), .cap_en(cap_en),
    .psw_in(psw_in), .cr0_in(cr0_in), .ec_in(ec_mode),
    .fld_in(ins_text[FLD_W-1:0]),
    .byte_en(byte_en), .byte_in(fetch_data), .load_en(load_en),
    .psw_q(psw_q), .base_q(base_q), .cr0_q(cr0_q), .ec_q(ec_q),
    .fld_q(fetch_fld)
  );

  ssm_gate #(.PSW_W(PSW_W), .CR_W(CR_W)) u_gate (
    .psw(base_q), .cr0(cr0_q), .pre_exc(pre_exc)
  );

  ssm_spec_chk #(.MASK_W(MASK_W)) u_spec (
    .ec(ec_q), .new_byte(psw_q[PSW_W-1:KEEP_W]), .spec_bad(spec_bad)
  );

  ssm_ctrl #(.ILC_W(ILC_W)) u_ctrl (
    .clk(clk), .rst_sn(rst_sn), .go(go), .pre_exc(pre_exc),
    .fetch_ack(fetch_ack), .fetch_err(fetch_err), .spec_bad(spec_bad),
    .cap_en(cap_en), .byte_en(byte_en), .load_en(load_en),
    .fetch_req(fetch_req), .done(done), .completed(completed),
    .exc_q(exc_q), .ilc(ilc)
  );

  assign exc_code = exc_q;
  assign psw_out  = psw_q;

  AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> (psw_out[KEEP_W-1:0] == base_q[KEEP_W-1:0])); // R1
  AST_SUPPRESS_KEEPS_PSW: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && !completed) |-> (psw_out == base_q)); // R4
  AST_BC_NO_SPEC: assert property (@(posedge clk) disable iff (!rst_sn)
    (done && !ec_q) |-> (exc_code != 3'd4)); // R7
endmodule

// File: tb/tb_ssm_exec.sv
module tb_ssm_exec;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        go;
  logic [31:0] ins_text;
  logic [63:0] psw_in;
  logic [31:0] cr0_in;
  logic        ec_mode;
  logic        fetch_req;
  logic [15:0] fetch_fld;
  logic        fetch_ack;
  logic        fetch_err;
  logic [7:0]  fetch_data;
  logic        done;
  logic        completed;
  logic [2:0]  exc_code;
  logic [1:0]  ilc;
  logic [63:0] psw_out;

  ssm_exec dut (
    .clk(clk), .rst_n(rst_n), .go(go), .ins_text(ins_text),
    .psw_in(psw_in), .cr0_in(cr0_in), .ec_mode(ec_mode),
    .fetch_req(fetch_req), .fetch_fld(fetch_fld), .fetch_ack(fetch_ack),
    .fetch_err(fetch_err), .fetch_data(fetch_data), .done(done),
    .completed(completed), .exc_code(exc_code), .ilc(ilc), .psw_out(psw_out)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [63:0] psw;
    logic [2:0]  exc;
    logic        cmp;
    logic [1:0]  ilc;
    int          nfetch;
  } exp_t;

  exp_t  sb_q[$];
  string tag_q[$];
  int    total = 0;
  int    bad   = 0;
  int    fetch_cnt = 0;
  int    cycles = 0;
  bit    finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] p, input logic [31:0] c,
                        input logic e, input logic [31:0] ins,
                        input logic [7:0] b, input logic err, input string tag);
    exp_t x;
    x.psw = p; x.exc = 3'd0; x.cmp = 1'b0; x.nfetch = 0;
    if (p[48])      x.exc = 3'd1;
    else if (c[30]) x.exc = 3'd2;
    else begin
      x.nfetch = 1;
      if (err) x.exc = 3'd3;
      else begin
        x.psw = {b, p[55:0]};
        x.cmp = 1'b1;
        if (e && ((b & 8'hBC) != 8'h00)) x.exc = 3'd4;
      end
    end
    x.ilc = (x.exc != 3'd0) ? 2'd2 : 2'd0;
    sb_q.push_back(x);
    tag_q.push_back(tag);
    fetch_cnt = 0;
    @(negedge clk);
    go = 1'b1; ins_text = ins; psw_in = p; cr0_in = c; ec_mode = e;
    @(negedge clk);
    go = 1'b0;
    ins_text = ~ins; psw_in = ~p; cr0_in = ~c; ec_mode = ~e;
    forever begin
      @(negedge clk);
      if (fetch_ack) begin
        fetch_ack = 1'b0; fetch_err = 1'b0; fetch_data = 8'h00;
      end else if (fetch_req) begin
        chk(fetch_fld == ins[15:0], "R8", "fetch_fld", 64'(fetch_fld), 64'(ins[15:0]));
        fetch_cnt++;
        fetch_ack = 1'b1; fetch_err = err; fetch_data = b;
      end
      if (done) break;
    end
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", 64'(done), 64'd0);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t  x;
          string t;
          x = sb_q.pop_front();
          t = tag_q.pop_front();
          chk(psw_out == x.psw, t, "psw", psw_out, x.psw);
          chk(exc_code == x.exc, t, "exc", 64'(exc_code), 64'(x.exc));
          chk(completed == x.cmp, t, "completed", 64'(completed), 64'(x.cmp));
          chk(ilc == x.ilc, "R9", "ilc", 64'(ilc), 64'(x.ilc));
          chk(fetch_cnt == x.nfetch, t, "fetches", 64'(fetch_cnt), 64'(x.nfetch));
        end
      end
    end
  end

  initial begin : watchdog
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=<20000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : stim
    go = 1'b0; ins_text = '0; psw_in = '0; cr0_in = '0; ec_mode = 1'b0;
    fetch_ack = 1'b0; fetch_err = 1'b0; fetch_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && fetch_req == 1'b0, "R9", "reset outputs",
        64'({done, fetch_req}), 64'd0);
    chk(psw_out == 64'd0, "R1", "reset psw", psw_out, 64'd0);

    // R1: EC mode, byte with only bits 6,7 set
    run_op(64'h0004_1234_5678_9ABC, 32'h0000_0000, 1'b1, 32'hB110_4123, 8'h03, 1'b0, "R1");
    // R7: BC mode, all ones accepted
    run_op(64'h1200_0003_DEAD_BEEF, 32'h8000_0001, 1'b0, 32'h8000_2001, 8'hFF, 1'b0, "R7");
    // R2: problem state
    run_op(64'h0001_0000_0000_0000, 32'h0000_0000, 1'b1, 32'h8000_0010, 8'h00, 1'b0, "R2");
    // R3: supervisor with suppression bit
    run_op(64'h0700_3000_0000_0001, 32'h4000_0000, 1'b1, 32'h8000_0020, 8'h00, 1'b0, "R3");
    // R5: both set, privileged wins
    run_op(64'h0001_0000_0000_0002, 32'h4000_0000, 1'b0, 32'h8000_0030, 8'h00, 1'b0, "R5");
    // R4: access error on fetch
    run_op(64'h4400_0000_0000_0000, 32'hBFFF_FFFF, 1'b1, 32'h8000_0040, 8'h55, 1'b1, "R4");
    // R6: EC mode, reserved bits in byte
    run_op(64'h0008_0000_1111_2222, 32'h0000_0000, 1'b1, 32'h8000_0050, 8'h80, 1'b0, "R6");
    run_op(64'h0008_0000_1111_2222, 32'h0000_0000, 1'b1, 32'h8000_0060, 8'h04, 1'b0, "R6");
    // R6: bit 1 and bits 6,7 are not reserved
    run_op(64'h0008_0000_1111_2222, 32'h0000_0000, 1'b1, 32'h8000_0070, 8'h43, 1'b0, "R6");
    // R7: BC mode, reserved bits set, no spec check
    run_op(64'hFF00_0000_0000_0000, 32'h0000_0000, 1'b0, 32'h8000_0080, 8'hBC, 1'b0, "R7");
    // R8: same operation, different bits 8-15
    run_op(64'h0000_1000_0000_0000, 32'h0000_0000, 1'b1, 32'h8000_1234, 8'h02, 1'b0, "R8");
    run_op(64'h0000_1000_0000_0000, 32'h0000_0000, 1'b1, 32'h80FF_1234, 8'h02, 1'b0, "R8");
    // R4: access error in BC mode
    run_op(64'h0000_0000_0000_FFFF, 32'h0000_0000, 1'b0, 32'h8000_0090, 8'hAA, 1'b1, "R4");

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R9", "pending results", 64'(sb_q.size()), 64'd0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule